// File: doc/BRIEF.md
# Peripheral Stream DMA Channel

This block is one DMA channel that moves a stream of bytes between system memory and one of up to eight byte-wide peripherals. Software programs a direction, a peripheral select code, a byte count and a memory address through a small register window, then sets the start bit. The channel alternates between a memory request port and a valid/ready handshake toward the selected peripheral, one byte at a time, until the programmed number of bytes has moved.

The length is written as the number of bytes minus one. The counter steps down once per byte and wraps past zero to all ones, so a finished transfer reads 0xFFFFF. The address register steps up once per byte. Both can be read while the transfer runs. The start bit reads back as a live busy flag. A separate stop bit ends the transfer early. A normal finish produces a one-cycle interrupt pulse; an abort does not.

A global enable input gates the start of new transfers. Memory is a single-byte request port: a request is taken in the cycle `mem_gnt` is high, and for reads `mem_rdata` is valid in that same cycle.

Top module: `pstream_dma`

## Requirements
- R1: Writing 1 to bit 0 of the command register (offset 0x00), with bit 1 clear, starts a transfer. Bit 0 of that register reads 1 from the cycle after the write until the transfer ends, then reads 0. While idle the channel makes no memory request and drives no peripheral handshake.
- R2: Writing 1 to bit 1 of the command register while busy aborts the transfer in the next cycle. Busy clears, no interrupt is raised, and the count and address keep the values they held at the abort.
- R3: Control bit 0 selects the direction. With 1, each byte is read from memory and then offered to the peripheral. With 0, each byte is taken from the peripheral and then written to memory. Bytes arrive unchanged and in order.
- R4: Control bits 3:1 form a select code that picks peripheral index 0 to 7, for example 2 for a serial port and 6 for an infrared port. Only that peripheral's `per_tx_valid` or `per_rx_ready` bit is ever asserted.
- R5: The count register (offset 0x10, 20 bits) holds bytes minus one. It decrements by one per byte moved and reads 0xFFFFF after the final byte.
- R6: The address register (offset 0x14) increments by one per byte. `mem_addr` carries its current value, and it can be read at any time during the transfer.
- R7: After the final byte the `irq` output is high for exactly one cycle, in the same cycle that busy first reads 0.
- R8: The control register is at offset 0x04, with the direction in bit 0 and the select code in bits 3:1. All registers read 0 after reset. Any offset other than 0x00, 0x04, 0x10 and 0x14 reads 0.
- R9: Writes to the control, count and address registers have no effect while busy.
- R10: While `glob_en` is low, a start write is ignored and the channel stays idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| glob_en | input | 1 | Global enable; low blocks a transfer from starting |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` (combinational) |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 32 | Memory byte address |
| mem_wdata | output | 8 | Memory write byte |
| mem_gnt | input | 1 | Memory accepts the request this cycle |
| mem_rdata | input | 8 | Memory read byte, valid with `mem_gnt` |
| per_tx_valid | output | 8 | Byte offered to peripheral i (bit i) |
| per_tx_data | output | 8 | Byte offered to the selected peripheral |
| per_tx_ready | input | 8 | Peripheral i accepts the offered byte |
| per_rx_valid | input | 8 | Peripheral i has a byte |
| per_rx_data | input | 64 | Byte of peripheral i in bits 8i+7:8i |
| per_rx_ready | output | 8 | Channel takes a byte from peripheral i |
| irq | output | 1 | Completion pulse |

## Verification
The bench drives stalls on memory and on both peripheral handshakes. It checks every byte against a queue model, and checks the live count against a decrementing model in every cycle. A counter that failed to wrap, or that stepped on a stalled cycle, would show the wrong count at once. The single-byte transfer covers a count of zero, where a design that tested the count after the decrement would run on for 2^20 bytes. The abort is placed at a point where a handshake may complete in the same cycle. A design that let that byte through, raised the interrupt, or reloaded the counters would fail the held count, address and interrupt checks. Writes to the control, count and address registers during a transfer, and a start with the enable low, must change neither the counters nor the interrupt count.

// File: rtl/pstream_dma_pkg.sv
package pstream_dma_pkg;
    localparam int REG_W = 32;
    localparam int OFS_W = 8;
    localparam logic [OFS_W-1:0] OFS_CMD  = 8'h00;
    localparam logic [OFS_W-1:0] OFS_CTRL = 8'h04;
    localparam logic [OFS_W-1:0] OFS_CNT  = 8'h10;
    localparam logic [OFS_W-1:0] OFS_ADDR = 8'h14;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_MEM  = 2'd1,
        ST_PER  = 2'd2
    } seq_state_t;
endpackage

// File: rtl/pdma_core.sv
module pdma_core
    import pstream_dma_pkg::*;
#(
    parameter int CNT_W  = 20,
    parameter int ADDR_W = 32,
    parameter int SEL_W  = 3,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              glob_en,
    input  logic              reg_we,
    input  logic [OFS_W-1:0]  reg_addr,
    input  logic [REG_W-1:0]  reg_wdata,
    input  logic              mem_gnt,
    input  logic [DATA_W-1:0] mem_rdata,
    input  logic              per_ack,
    input  logic [DATA_W-1:0] per_rdata,
    output logic              busy,
    output logic              dir,
    output logic [SEL_W-1:0]  sel,
    output logic [CNT_W-1:0]  cnt,
    output logic [ADDR_W-1:0] addr,
    output logic              mem_req,
    output logic              mem_we,
    output logic [DATA_W-1:0] mem_wdata,
    output logic              per_req,
    output logic [DATA_W-1:0] per_wdata,
    output logic              irq
);
    typedef struct packed {
        seq_state_t        state;
        logic              dir;
        logic [SEL_W-1:0]  sel;
        logic [CNT_W-1:0]  cnt;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] hold;
        logic              irq;
    } core_t;

    core_t d, q;
    logic  cmd_wr, step;
    logic  unused_wdata;

    assign unused_wdata = ^reg_wdata;

    always_comb begin
        d      = q;
        d.irq  = 1'b0;
        step   = 1'b0;
        cmd_wr = reg_we && (reg_addr == OFS_CMD);
        if (q.state == ST_IDLE) begin
            if (reg_we && reg_addr == OFS_CTRL) begin
                d.dir = reg_wdata[0];
                d.sel = reg_wdata[SEL_W:1];
            end
            if (reg_we && reg_addr == OFS_CNT)  d.cnt  = reg_wdata[CNT_W-1:0];
            if (reg_we && reg_addr == OFS_ADDR) d.addr = reg_wdata[ADDR_W-1:0];
            if (cmd_wr && reg_wdata[0] && !reg_wdata[1] && glob_en)
                d.state = q.dir ? ST_MEM : ST_PER;
        end else if (cmd_wr && reg_wdata[1]) begin
            d.state = ST_IDLE;
        end else begin
            case (q.state)
                ST_MEM: if (mem_gnt) begin
                    if (q.dir) begin
                        d.hold  = mem_rdata;
                        d.state = ST_PER;
                    end else begin
                        step = 1'b1;
                    end
                end
                ST_PER: if (per_ack) begin
                    if (q.dir) begin
                        step = 1'b1;
                    end else begin
                        d.hold  = per_rdata;
                        d.state = ST_MEM;
                    end
                end
                default: d.state = ST_IDLE;
            endcase
        end
        if (step) begin
            d.cnt  = q.cnt - CNT_W'(1);
            d.addr = q.addr + ADDR_W'(1);
            if (q.cnt == '0) begin
                d.state = ST_IDLE;
                d.irq   = 1'b1;
            end else begin
                d.state = q.dir ? ST_MEM : ST_PER;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign busy      = (q.state != ST_IDLE);
    assign dir       = q.dir;
    assign sel       = q.sel;
    assign cnt       = q.cnt;
    assign addr      = q.addr;
    assign mem_req   = (q.state == ST_MEM);
    assign mem_we    = !q.dir;
    assign mem_wdata = q.hold;
    assign per_req   = (q.state == ST_PER);
    assign per_wdata = q.hold;
    assign irq       = q.irq;
endmodule

// File: rtl/pdma_route.sv
module pdma_route #(
    parameter int SEL_W  = 3,
    parameter int DATA_W = 8,
    localparam int NP    = 1 << SEL_W
) (
    input  logic [SEL_W-1:0]     sel,
    input  logic                 dir,
    input  logic                 per_req,
    input  logic [DATA_W-1:0]    per_wdata,
    input  logic [NP-1:0]        tx_ready,
    input  logic [NP-1:0]        rx_valid,
    input  logic [NP*DATA_W-1:0] rx_data,
    output logic [NP-1:0]        tx_valid,
    output logic [DATA_W-1:0]    tx_data,
    output logic [NP-1:0]        rx_ready,
    output logic                 per_ack,
    output logic [DATA_W-1:0]    per_rdata
);
    for (genvar i = 0; i < NP; i++) begin : g_port
        assign tx_valid[i] = per_req &&  dir && (sel == SEL_W'(i));
        assign rx_ready[i] = per_req && !dir && (sel == SEL_W'(i));
    end

    assign tx_data = per_wdata;
    assign per_ack = dir ? tx_ready[sel] : rx_valid[sel];

    always_comb begin
        per_rdata = '0;
        for (int i = 0; i < NP; i++)
            if (sel == SEL_W'(i)) per_rdata = rx_data[i*DATA_W +: DATA_W];
    end
endmodule

// File: rtl/pdma_rdmux.sv
module pdma_rdmux
    import pstream_dma_pkg::*;
#(
    parameter int CNT_W  = 20,
    parameter int ADDR_W = 32,
    parameter int SEL_W  = 3
) (
    input  logic [OFS_W-1:0]  reg_addr,
    input  logic              busy,
    input  logic              dir,
    input  logic [SEL_W-1:0]  sel,
    input  logic [CNT_W-1:0]  cnt,
    input  logic [ADDR_W-1:0] addr,
    output logic [REG_W-1:0]  rdata
);
    always_comb begin
        case (reg_addr)
            OFS_CMD:  rdata = REG_W'(busy);
            OFS_CTRL: rdata = REG_W'({sel, dir});
            OFS_CNT:  rdata = REG_W'(cnt);
            OFS_ADDR: rdata = REG_W'(addr);
            default:  rdata = '0;
        endcase
    end
endmodule

// File: rtl/pstream_dma.sv
module pstream_dma
    import pstream_dma_pkg::*;
#(
    parameter int CNT_W  = 20,
    parameter int ADDR_W = 32,
    parameter int SEL_W  = 3,
    parameter int DATA_W = 8,
    localparam int NP    = 1 << SEL_W
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 glob_en,
    input  logic                 reg_we,
    input  logic [OFS_W-1:0]     reg_addr,
    input  logic [REG_W-1:0]     reg_wdata,
    output logic [REG_W-1:0]     reg_rdata,
    output logic                 mem_req,
    output logic                 mem_we,
    output logic [ADDR_W-1:0]    mem_addr,
    output logic [DATA_W-1:0]    mem_wdata,
    input  logic                 mem_gnt,
    input  logic [DATA_W-1:0]    mem_rdata,
    output logic [NP-1:0]        per_tx_valid,
    output logic [DATA_W-1:0]    per_tx_data,
    input  logic [NP-1:0]        per_tx_ready,
    input  logic [NP-1:0]        per_rx_valid,
    input  logic [NP*DATA_W-1:0] per_rx_data,
    output logic [NP-1:0]        per_rx_ready,
    output logic                 irq
);
    logic              busy_w, dir_w, per_req_w, per_ack_w;
    logic [SEL_W-1:0]  sel_w;
    logic [CNT_W-1:0]  cnt_w;
    logic [DATA_W-1:0] per_wdata_w, per_rdata_w;

    pdma_core #(.CNT_W(CNT_W), .ADDR_W(ADDR_W), .SEL_W(SEL_W), .DATA_W(DATA_W)) u_core (
        .clk(clk), .rst_n(rst_n), .glob_en(glob_en),
        .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .mem_gnt(mem_gnt), .mem_rdata(mem_rdata),
        .per_ack(per_ack_w), .per_rdata(per_rdata_w),
        .busy(busy_w), .dir(dir_w), .sel(sel_w), .cnt(cnt_w), .addr(mem_addr),
        .mem_req(mem_req), .mem_we(mem_we), .mem_wdata(mem_wdata),
        .per_req(per_req_w), .per_wdata(per_wdata_w), .irq(irq)
    );

    pdma_route #(.SEL_W(SEL_W), .DATA_W(DATA_W)) u_route (
        .sel(sel_w), .dir(dir_w), .per_req(per_req_w), .per_wdata(per_wdata_w),
        .tx_ready(per_tx_ready), .rx_valid(per_rx_valid), .rx_data(per_rx_data),
        .tx_valid(per_tx_valid), .tx_data(per_tx_data), .rx_ready(per_rx_ready),
        .per_ack(per_ack_w), .per_rdata(per_rdata_w)
    );

    pdma_rdmux #(.CNT_W(CNT_W), .ADDR_W(ADDR_W), .SEL_W(SEL_W)) u_rdmux (
        .reg_addr(reg_addr), .busy(busy_w), .dir(dir_w), .sel(sel_w),
        .cnt(cnt_w), .addr(mem_addr), .rdata(reg_rdata)
    );
endmodule

// File: rtl/pdma_checker.sv
module pdma_checker #(
    parameter int CNT_W = 20,
    parameter int NP    = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             glob_en,
    input logic             reg_we,
    input logic [7:0]       reg_addr,
    input logic [31:0]      reg_wdata,
    input logic             busy,
    input logic             dir,
    input logic [CNT_W-1:0] cnt,
    input logic             mem_req,
    input logic             mem_we,
    input logic [NP-1:0]    tx_valid,
    input logic [NP-1:0]    rx_ready,
    input logic             irq
);
    logic stop_wr;
    assign stop_wr = reg_we && (reg_addr == 8'h00) && reg_wdata[1];

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!mem_req && tx_valid == '0 && rx_ready == '0)); // R1
    AST_ABORT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && stop_wr) |=> (!busy && !irq)); // R2
    AST_RX_NO_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !dir && mem_req) |-> mem_we); // R3
    AST_ONE_PORT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({tx_valid, rx_ready})); // R4
    AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> (cnt == $past(cnt) || cnt == $past(cnt) - CNT_W'(1))); // R5
    AST_DONE_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(busy) && !$past(stop_wr)) |-> irq); // R7
    AST_IRQ_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq); // R7
    AST_IRQ_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> !busy); // R7
    AST_EN_GATES: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(glob_en)); // R10
endmodule

bind pstream_dma pdma_checker #(.CNT_W(CNT_W), .NP(NP)) u_chk (
    .clk(clk), .rst_n(rst_n), .glob_en(glob_en), .reg_we(reg_we),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .busy(busy_w), .dir(dir_w),
    .cnt(cnt_w), .mem_req(mem_req), .mem_we(mem_we), .tx_valid(per_tx_valid),
    .rx_ready(per_rx_ready), .irq(irq)
);

// File: tb/pstream_dma_test.sv
`timescale 1ns/1ps
module pstream_dma_test;
    logic        clk = 1'b0, rst_n = 1'b0, glob_en = 1'b1;
    logic        reg_we = 1'b0;
    logic [7:0]  reg_addr = 8'h00;
    logic [31:0] reg_wdata = '0, reg_rdata;
    logic        mem_req, mem_we, mem_gnt = 1'b0;
    logic [31:0] mem_addr;
    logic [7:0]  mem_wdata, mem_rdata, per_tx_data;
    logic [7:0]  per_tx_valid, per_tx_ready = '0, per_rx_valid = '0, per_rx_ready;
    logic [63:0] per_rx_data = '0;
    logic        irq;

    logic [7:0]  bmem [0:255];
    logic [7:0]  byteq [$];
    int          checks = 0, errors = 0;
    bit          mon = 1'b0, irq_pend = 1'b0;
    int          irq_cnt = 0, cur_sel = 0, cur_dir = 0;
    logic [19:0] exp_cnt = '0;
    logic [31:0] exp_addr = '0;
    logic [15:0] lfsr = 16'hACE1;

    always #4 clk = ~clk;

    assign mem_rdata = bmem[mem_addr[7:0]];

    pstream_dma uut (
        .clk(clk), .rst_n(rst_n), .glob_en(glob_en), .reg_we(reg_we),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_gnt(mem_gnt), .mem_rdata(mem_rdata),
        .per_tx_valid(per_tx_valid), .per_tx_data(per_tx_data),
        .per_tx_ready(per_tx_ready), .per_rx_valid(per_rx_valid),
        .per_rx_data(per_rx_data), .per_rx_ready(per_rx_ready), .irq(irq)
    );

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    // stall patterns and peripheral source bytes
    initial begin
        for (int i = 0; i < 256; i++) bmem[i] = 8'(i * 13 + 7);
        forever begin
            @(negedge clk);
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            mem_gnt      = lfsr[0] | lfsr[3];
            per_tx_ready = {8{lfsr[1] | lfsr[5]}};
            per_rx_valid = {8{lfsr[2] | lfsr[6]}};
            for (int p = 0; p < 8; p++) per_rx_data[p*8 +: 8] = lfsr[7:0] ^ 8'(p * 37);
        end
    end

    // cycle-by-cycle reference model
    always @(negedge clk) begin
        #2;
        if (rst_n && mon) begin
            automatic bit stop_now = reg_we && reg_addr == 8'h00 && reg_wdata[1];
            automatic bit done = 1'b0;
            automatic logic [7:0] other = ~(8'b1 << cur_sel);
            check(irq === irq_pend, "R7 irq", 32'(irq), 32'(irq_pend));
            if (irq) irq_cnt++;
            irq_pend = 1'b0;
            if (!reg_we && reg_addr == 8'h10)
                check(reg_rdata == 32'(exp_cnt), "R5 live count", reg_rdata, 32'(exp_cnt));
            check((per_tx_valid & other) == 0 && (per_rx_ready & other) == 0,
                  "R4 routing", {per_tx_valid, per_rx_ready}, 32'(cur_sel));
            check(cur_dir ? per_rx_ready == 0 : per_tx_valid == 0, "R3 direction",
                  {per_tx_valid, per_rx_ready}, 32'(cur_dir));
            if (!stop_now) begin
                if (mem_req && !mem_we && mem_gnt) begin
                    check(mem_addr == exp_addr, "R6 read addr", mem_addr, exp_addr);
                    byteq.push_back(bmem[mem_addr[7:0]]);
                end
                if ((per_rx_valid & per_rx_ready) != 0)
                    byteq.push_back(per_rx_data[cur_sel*8 +: 8]);
                if ((per_tx_valid & per_tx_ready) != 0) begin
                    if (byteq.size() == 0) check(1'b0, "R3 tx underflow", 32'(per_tx_data), 0);
                    else check(per_tx_data == byteq.pop_front(), "R3 tx byte", 32'(per_tx_data), 32'(per_tx_data));
                    done = 1'b1;
                end
                if (mem_req && mem_we && mem_gnt) begin
                    check(mem_addr == exp_addr, "R6 write addr", mem_addr, exp_addr);
                    if (byteq.size() == 0) check(1'b0, "R3 mem underflow", 32'(mem_wdata), 0);
                    else check(mem_wdata == byteq.pop_front(), "R3 mem byte", 32'(mem_wdata), 32'(mem_wdata));
                    bmem[mem_addr[7:0]] = mem_wdata;
                    done = 1'b1;
                end
                if (done) begin
                    if (exp_cnt == 0) irq_pend = 1'b1;
                    exp_cnt  = exp_cnt - 20'd1;
                    exp_addr = exp_addr + 32'd1;
                end
            end
        end
    end

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0; reg_addr = 8'h10;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] v);
        @(negedge clk);
        reg_addr = a;
        #1 v = reg_rdata;
    endtask

    task automatic setup(input int dir, input int sel, input int n, input logic [31:0] base);
        logic [31:0] v;
        mon = 1'b0;
        wr(8'h04, 32'((sel << 1) | dir));
        wr(8'h10, 32'(n - 1));
        wr(8'h14, base);
        rd(8'h04, v); check(v == 32'((sel << 1) | dir), "R8 ctrl readback", v, 32'((sel << 1) | dir));
        rd(8'h10, v); check(v == 32'(n - 1), "R8 count readback", v, 32'(n - 1));
        cur_dir = dir; cur_sel = sel;
        exp_cnt = 20'(n - 1); exp_addr = base;
    endtask

    task automatic go();
        logic [31:0] v;
        byteq.delete();
        irq_pend = 1'b0;
        mon = 1'b1;
        wr(8'h00, 32'h1);
        rd(8'h00, v); check(v == 1, "R1 busy after start", v, 1);
        reg_addr = 8'h10;
    endtask

    task automatic wait_done(input int base_irq);
        int t = 0;
        reg_addr = 8'h10;
        while (irq_cnt == base_irq && t < 3000) begin @(negedge clk); t++; end
        check(t < 3000, "R1 completion", 32'(t), 3000);
        repeat (2) @(negedge clk);
    endtask

    task automatic final_checks(input logic [31:0] end_addr, input int base_irq);
        logic [31:0] v;
        rd(8'h00, v); check(v == 0, "R1 busy clear", v, 0);
        rd(8'h10, v); check(v == 32'hFFFFF, "R5 final count", v, 32'hFFFFF);
        rd(8'h14, v); check(v == end_addr, "R6 final addr", v, end_addr);
        check(irq_cnt - base_irq == 1, "R7 irq count", 32'(irq_cnt - base_irq), 1);
        check(byteq.size() == 0, "R3 leftover bytes", 32'(byteq.size()), 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        finish_run();
    end

    initial begin
        logic [31:0] v;
        int b;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R8: reset values and unimplemented offsets
        rd(8'h00, v); check(v == 0, "R8 reset cmd", v, 0);
        rd(8'h04, v); check(v == 0, "R8 reset ctrl", v, 0);
        rd(8'h10, v); check(v == 0, "R8 reset count", v, 0);
        rd(8'h14, v); check(v == 0, "R8 reset addr", v, 0);
        rd(8'h08, v); check(v == 0, "R8 unused 0x08", v, 0);
        rd(8'h18, v); check(v == 0, "R8 unused 0x18", v, 0);

        // memory to serial port (select 2)
        setup(1, 2, 8, 32'h20); b = irq_cnt; go(); wait_done(b); final_checks(32'h28, b);
        // infrared port (select 6) to memory
        setup(0, 6, 5, 32'h80); b = irq_cnt; go(); wait_done(b); final_checks(32'h85, b);
        // single byte: programmed count of zero
        setup(1, 0, 1, 32'hF0); b = irq_cnt; go(); wait_done(b); final_checks(32'hF1, b);

        // R9: writes while busy are ignored
        setup(1, 2, 12, 32'h40); b = irq_cnt; go();
        repeat (3) @(negedge clk);
        wr(8'h04, 32'hC);
        wr(8'h10, 32'h3);
        wr(8'h14, 32'h99);
        rd(8'h14, v); check(v == exp_addr, "R6 live addr", v, exp_addr);
        wait_done(b);
        rd(8'h04, v); check(v == 32'h5, "R9 ctrl held", v, 32'h5);
        final_checks(32'h4C, b);

        // R2: abort mid-way
        setup(0, 6, 40, 32'h00); b = irq_cnt; go();
        repeat (15) @(negedge clk);
        wr(8'h00, 32'h2);
        repeat (5) @(negedge clk);
        rd(8'h00, v); check(v == 0, "R2 busy cleared", v, 0);
        rd(8'h10, v); check(v == 32'(exp_cnt), "R2 count held", v, 32'(exp_cnt));
        rd(8'h14, v); check(v == exp_addr, "R2 addr held", v, exp_addr);
        check(irq_cnt == b, "R2 no irq", 32'(irq_cnt - b), 0);
        check(exp_cnt != 20'hFFFFF, "R2 stopped early", 32'(exp_cnt), 0);

        // R10: global enable low blocks start
        setup(1, 2, 4, 32'h60);
        glob_en = 1'b0;
        wr(8'h00, 32'h1);
        repeat (6) begin
            @(negedge clk); #2;
            check(!mem_req && per_tx_valid == 0, "R10 no activity", 32'(mem_req), 0);
        end
        rd(8'h00, v); check(v == 0, "R10 stays idle", v, 0);
        rd(8'h10, v); check(v == 3, "R10 count untouched", v, 3);
        glob_en = 1'b1;
        b = irq_cnt; go(); wait_done(b); final_checks(32'h64, b);

        finish_run();
    end
endmodule